// File: doc/BRIEF.md
# Multi-Field Event Key Mapper

The mapper turns a raw 32-bit event word, such as one taken from a network or USB packet, into a routing key. Each event comes with a pipe number, and that number selects one of two independent configuration sets. Each set has four fields. For each field the block ANDs the event word with the field's mask. It then shifts the masked value by the field's signed shift amount and saturates the result at the field's limit. The four field results are merged with a bitwise OR, and the pipe's base key is added to the merged value.

Events enter on a valid/ready stream and keys leave on a second valid/ready stream. The datapath is a two-stage pipeline that accepts one event per cycle when the output side is ready. Configuration is written through a simple register write port. The write address selects the base key of a pipe, or the mask, shift or limit of one field of a pipe.

Top module: `evkey_mapper`

## Requirements
- R1: A field is formed by ANDing the event word with the field's mask first; the shift is applied to the masked value, not the mask to the shifted word.
- R2: The shift register holds a 6-bit two's-complement value taken from write data bits 5:0. A zero or positive value shifts the masked value right by that many bits.
- R3: A negative shift value shifts the masked value left by its magnitude, with bits dropped above bit 31 (a value of -32 yields zero).
- R4: A shifted field value greater than the field's limit is replaced by the limit. A value equal to or below the limit passes unchanged, and the comparison is unsigned.
- R5: The output key is the bitwise OR of the four field values plus the selected pipe's base key, modulo 2^32.
- R6: `in_pipe` selects which pipe's base key, masks, shifts and limits are used for that event.
- R7: A write with `cfg_we` high sets one register. Address 80+p is the base key of pipe p. Addresses 96+4p+f, 112+4p+f and 128+4p+f are the mask, shift and limit of field f of pipe p. Writes to any other address change nothing.
- R8: Reset clears every configuration register to zero and drops `out_valid`. With the reset configuration, every event maps to key 0.
- R9: Keys come out in input order, two cycles after acceptance, at up to one per cycle. While `out_valid` is high and `out_ready` is low, the key is held, `in_ready` is low, and no event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Event word valid |
| in_ready | output | 1 | Mapper can accept an event |
| in_pipe | input | 1 | Pipe selecting the configuration set |
| in_word | input | 32 | Raw event word |
| out_valid | output | 1 | Routing key valid |
| out_ready | input | 1 | Downstream accepts the key |
| out_key | output | 32 | Routing key |

## Verification
Single-field configurations separate the individual steps. A byte mask combined with a right shift shows whether masking happens before shifting. A nibble mask with a negative shift shows the left direction, and a shift of -32 shows that all bits are dropped. Event words below, equal to and above a limit test the saturation edge. Multi-field configurations on both pipes, with a base key near 2^32, test the OR merge, pipe selection and wrap-around. Unmapped writes test that nothing else is disturbed. A randomised configuration with random output back-pressure tests ordering and holding under stalls.

// File: rtl/evkey_pkg.sv
package evkey_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 8;
  localparam int SHIFT_W    = 6;
  // Register window bases; slot index inside a window is pipe*fields + field
  localparam int OFS_BASE   = 80;
  localparam int OFS_MASK   = 96;
  localparam int OFS_SHIFT  = 112;
  localparam int OFS_LIMIT  = 128;
endpackage

// File: rtl/evkey_cfg_regs.sv
module evkey_cfg_regs #(
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int SHIFT_W  = 6,
  parameter int N_PIPES  = 2,
  parameter int N_FIELDS = 4,
  localparam int N_SLOTS = N_PIPES * N_FIELDS
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [WORD_W-1:0]                 wdata,
  output logic [N_PIPES-1:0][WORD_W-1:0]    base_key,
  output logic [N_SLOTS-1:0][WORD_W-1:0]    fld_mask,
  output logic [N_SLOTS-1:0][SHIFT_W-1:0]   fld_shift,
  output logic [N_SLOTS-1:0][WORD_W-1:0]    fld_limit
);
  import evkey_pkg::*;

  for (genvar p = 0; p < N_PIPES; p++) begin : g_base
    always_ff @(posedge clk) begin
      if (rst)
        base_key[p] <= '0;
      else if (we && (int'(addr) == OFS_BASE + p))
        base_key[p] <= wdata;
    end
  end

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        fld_mask[s]  <= '0;
        fld_shift[s] <= '0;
        fld_limit[s] <= '0;
      end else if (we) begin
        if (int'(addr) == OFS_MASK + s)  fld_mask[s]  <= wdata;
        if (int'(addr) == OFS_SHIFT + s) fld_shift[s] <= wdata[SHIFT_W-1:0];
        if (int'(addr) == OFS_LIMIT + s) fld_limit[s] <= wdata;
      end
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(base_key) && $stable(fld_mask) &&
             $stable(fld_shift) && $stable(fld_limit))); // R7
endmodule

// File: rtl/evkey_field_unit.sv
module evkey_field_unit #(
  parameter int WORD_W  = 32,
  parameter int SHIFT_W = 6
) (
  input  logic [WORD_W-1:0]  word,
  input  logic [WORD_W-1:0]  mask,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [WORD_W-1:0]  limit,
  output logic [WORD_W-1:0]  value
);
  logic [WORD_W-1:0]  masked;
  logic [WORD_W-1:0]  shifted;
  logic [SHIFT_W-1:0] magnitude;

  always_comb begin
    masked    = word & mask;
    magnitude = shift[SHIFT_W-1] ? (~shift + 1'b1) : shift;
    if (shift[SHIFT_W-1])
      shifted = masked << magnitude;
    else
      shifted = masked >> magnitude;
    value = (shifted > limit) ? limit : shifted;
  end
endmodule

// File: rtl/evkey_mapper.sv
module evkey_mapper #(
  parameter int WORD_W   = evkey_pkg::WORD_W,
  parameter int ADDR_W   = evkey_pkg::ADDR_W,
  parameter int SHIFT_W  = evkey_pkg::SHIFT_W,
  parameter int N_PIPES  = 2,
  parameter int N_FIELDS = 4,
  localparam int PIPE_W  = (N_PIPES > 1) ? $clog2(N_PIPES) : 1,
  localparam int N_SLOTS = N_PIPES * N_FIELDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIPE_W-1:0] in_pipe,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_key
);
  logic [N_PIPES-1:0][WORD_W-1:0]  base_key;
  logic [N_SLOTS-1:0][WORD_W-1:0]  fld_mask;
  logic [N_SLOTS-1:0][SHIFT_W-1:0] fld_shift;
  logic [N_SLOTS-1:0][WORD_W-1:0]  fld_limit;

  evkey_cfg_regs #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W),
    .N_PIPES(N_PIPES), .N_FIELDS(N_FIELDS)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .base_key(base_key), .fld_mask(fld_mask),
    .fld_shift(fld_shift), .fld_limit(fld_limit)
  );

  // Global advance: the whole pipe moves when the output slot frees up
  logic advance;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  // Stage 1: per-field mask, shift, clamp
  logic [N_FIELDS-1:0][WORD_W-1:0] fld_now;
  logic [N_FIELDS-1:0][WORD_W-1:0] s1_fld;
  logic [PIPE_W-1:0]               s1_pipe;
  logic                            s1_v;

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
    localparam int unsigned FI = f;
    logic [$clog2(N_SLOTS+1)-1:0] slot;
    assign slot = ($clog2(N_SLOTS+1))'(int'(in_pipe) * N_FIELDS + f);
    evkey_field_unit #(.WORD_W(WORD_W), .SHIFT_W(SHIFT_W)) u_fu (
      .word (in_word),
      .mask (fld_mask[slot]),
      .shift(fld_shift[slot]),
      .limit(fld_limit[slot]),
      .value(fld_now[FI])
    );
  end

  // Stage 2: OR merge and base key add
  logic [WORD_W-1:0] merged;
  always_comb begin
    merged = '0;
    for (int f = 0; f < N_FIELDS; f++) merged = merged | s1_fld[f];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      out_valid <= 1'b0;
    end else if (advance) begin
      s1_v      <= in_valid;
      out_valid <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      s1_fld  <= fld_now;
      s1_pipe <= in_pipe;
      out_key <= merged + base_key[s1_pipe];
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_key)); // R9
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R9
  AST_ACCEPT_ENTERS: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> s1_v); // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !out_valid); // R8
endmodule

// File: tb/sim_evkey_mapper.sv
`timescale 1ns/1ps
module sim_evkey_mapper;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        in_valid;
  logic        in_ready;
  logic [0:0]  in_pipe;
  logic [31:0] in_word;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_key;

  always #2.5 clk = ~clk;

  evkey_mapper u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_pipe(in_pipe), .in_word(in_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_key(out_key)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  bit bp_on    = 0;

  // Bench-side configuration model
  logic [31:0] m_base [2];
  logic [31:0] m_mask [8];
  int          m_shift[8];
  logic [31:0] m_limit[8];

  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(int p, logic [31:0] w);
    logic [31:0] key = '0;
    for (int f = 0; f < 4; f++) begin
      logic [31:0] m = w & m_mask[p*4+f];
      logic [31:0] v;
      int s = m_shift[p*4+f];
      if (s >= 0) v = m >> s; else v = m << (-s);
      if (v > m_limit[p*4+f]) v = m_limit[p*4+f];
      key |= v;
    end
    return key + m_base[p];
  endfunction

  task automatic cfg(int addr, logic [31:0] data);
    @(negedge clk);
    in_valid  = 1'b0;
    cfg_we    = 1'b1;
    cfg_addr  = 8'(addr);
    cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr >= 80 && addr < 82)        m_base[addr-80]   = data;
    else if (addr >= 96 && addr < 104)  m_mask[addr-96]   = data;
    else if (addr >= 112 && addr < 120) m_shift[addr-112] = int'($signed(data[5:0]));
    else if (addr >= 128 && addr < 136) m_limit[addr-128] = data;
  endtask

  task automatic fld(int p, int f, logic [31:0] mask, int sh, logic [31:0] lim);
    cfg(96 + p*4 + f, mask);
    cfg(112 + p*4 + f, 32'(sh));
    cfg(128 + p*4 + f, lim);
  endtask

  task automatic send(int p, logic [31:0] w, string req);
    bit acc;
    exp_q.push_back(model(p, w));
    tag_q.push_back(req);
    do begin
      @(negedge clk);
      in_valid = 1'b1;
      in_pipe  = 1'(p);
      in_word  = w;
      #1 acc = in_ready;
      @(posedge clk);
    end while (!acc);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R9 unexpected key", out_key, 32'hxxxxxxxx);
        end else begin
          string t = tag_q.pop_front();
          check(t, out_key, exp_q.pop_front());
        end
      end
    end
  end

  // Output back-pressure
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1 out_ready = bp_on ? 1'($urandom % 2) : 1'b1;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_mask[i] = '0; m_shift[i] = 0; m_limit[i] = '0;
    end
    m_base[0] = '0; m_base[1] = '0;
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_pipe = '0; in_word = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R8 out_valid after reset", 32'(out_valid), 32'd0);
    check("R8 in_ready after reset", 32'(in_ready), 32'd1);
    send(0, 32'hFFFF_FFFF, "R8 reset config key");
    send(1, 32'h1234_5678, "R8 reset config key pipe1");
    drain();

    // R1: mask first then shift
    fld(0, 0, 32'h0000_FF00, 8, 32'hFFFF_FFFF);
    send(0, 32'h1234_5678, "R1 mask before shift");
    // R2: right shift
    fld(0, 1, 32'hFF00_0000, 24, 32'hFFFF_FFFF);
    send(0, 32'hAB00_0000, "R2 right shift");
    drain();
    // R3: left shift and -32
    fld(0, 0, 32'h0000_000F, -4, 32'hFFFF_FFFF);
    fld(0, 1, 32'h0000_0000, 0, 32'h0);
    send(0, 32'h0000_0009, "R3 left shift");
    send(0, 32'hF000_0007, "R3 left shift drops top");
    drain();
    fld(0, 0, 32'hFFFF_FFFF, -32, 32'hFFFF_FFFF);
    send(0, 32'hDEAD_BEEF, "R3 shift -32 gives zero");
    drain();
    // R4: clamp
    fld(0, 0, 32'h0, 0, 32'h0);
    fld(0, 3, 32'h0000_00FF, 0, 32'h40);
    send(0, 32'h0000_0078, "R4 above limit");
    send(0, 32'h0000_0040, "R4 equal limit");
    send(0, 32'h0000_0030, "R4 below limit");
    fld(0, 2, 32'hFFFF_FFFF, 0, 32'h7FFF_FFFF);
    send(0, 32'h8000_0000, "R4 unsigned compare");
    drain();
    // R5: OR merge plus base, wrap
    fld(0, 0, 32'h0000_000F, -8, 32'hFFFF_FFFF);
    fld(0, 2, 32'h0000_00F0, 4, 32'hFFFF_FFFF);
    cfg(80, 32'h1000_0000);
    send(0, 32'h0000_00A5, "R5 or merge plus base");
    cfg(80, 32'hFFFF_FFF0);
    send(0, 32'h0000_0022, "R5 base wraps");
    drain();
    // R6: pipe selection
    cfg(81, 32'h0002_0000);
    fld(1, 0, 32'hFFFF_0000, 16, 32'h0000_0FFF);
    fld(1, 1, 32'h0000_00FF, -12, 32'hFFFF_FFFF);
    send(1, 32'h1234_0056, "R6 pipe1 config");
    send(0, 32'h1234_0056, "R6 pipe0 config");
    send(1, 32'h0001_00FF, "R6 pipe1 again");
    drain();
    // R7: unmapped writes ignored, mapped slot hits right field
    cfg(84, 32'hFFFF_FFFF);
    cfg(104, 32'hFFFF_FFFF);
    cfg(120, 32'h0000_0001);
    cfg(79, 32'hFFFF_FFFF);
    cfg(136, 32'h0);
    send(0, 32'h5A5A_5A5A, "R7 unmapped writes pipe0");
    send(1, 32'h5A5A_5A5A, "R7 unmapped writes pipe1");
    drain();
    cfg(112 + 5, 32'h0000_003C);
    send(1, 32'h0000_0003, "R7 pipe1 field1 shift slot");
    drain();
    // R9: latency
    send(0, 32'h0000_0011, "R9 latency key");
    @(negedge clk);
    in_valid = 1'b0;
    #1 check("R9 not valid after one cycle", 32'(out_valid), 32'd0);
    @(negedge clk);
    #1 check("R9 valid after two cycles", 32'(out_valid), 32'd1);
    drain();
    // R9: random config, burst under back-pressure
    for (int s = 0; s < 8; s++)
      fld(s / 4, s % 4, $urandom, int'($urandom % 64) - 32, $urandom);
    cfg(80, $urandom);
    cfg(81, $urandom);
    bp_on = 1;
    for (int i = 0; i < 40; i++)
      send(int'($urandom % 2), $urandom, "R9 ordered under back-pressure");
    drain();
    bp_on = 0;
    for (int i = 0; i < 10; i++)
      send(i % 2, $urandom, "R9 back-to-back");
    drain();
    check("R9 all keys delivered", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule